// File: doc/BRIEF.md
# Software-Managed Translation Buffer: Entry Fill and Tag Lookup

This block holds the entries of a translation buffer that software fills itself, plus a bank of control registers. Each entry pairs a tag word with a data word. In the data word, bit 63 marks the entry valid and bit 6 marks it locked against replacement. Requests arrive one per cycle on a single request port. An opcode chooses among six actions: register write, register read, automatic fill, indexed write, indexed entry read and tag search.

An automatic fill chooses the slot in hardware. It takes the lowest-numbered invalid slot. If no slot is invalid, it takes the lowest-numbered slot whose lock bit is clear. If every slot is valid and locked, the fill is dropped and a flag reports it. Both kinds of entry write take the tag from control register 6 and the data word from the request. A tag search returns the stored tag of the lowest valid entry whose tag equals the request word, or zero with a miss flag. Slot choice and search each resolve in one cycle through priority encoders. Results appear one cycle after the request.

Top module: `tlb_fill_lookup`

## Requirements
- R1: After reset, every entry reads as zero, so every entry is invalid. Every control register reads as zero, and rspValid, rspMiss and fillFail are low.
- R2: The opcode values on reqOp are 0 register write, 1 register read, 2 automatic fill, 3 indexed entry write, 4 indexed entry read and 5 tag search. A register access selects register reqAddr[6:3]. A read raises rspValid for one cycle, in the cycle after the request, with the register value on rspData.
- R3: A write to register 3, the fault-status register, stores zero whatever the write data, so that register always reads back as zero.
- R4: When at least one entry is invalid (data bit 63 clear), an automatic fill writes the lowest-indexed invalid entry. The tag comes from register 6 and the data word from reqWdata.
- R5: When every entry is valid, an automatic fill writes the lowest-indexed entry whose lock bit (data bit 6) is clear.
- R6: When every entry is valid and locked, an automatic fill changes no entry. fillFail is then high for exactly one cycle, the cycle after the request.
- R7: An indexed entry write targets entry reqAddr[8:3], whatever that entry's valid or lock state. Its tag comes from register 6 and its data word from reqWdata. Other address bits have no effect.
- R8: An indexed entry read returns the data word of entry reqAddr[8:3] on rspData, with rspValid, one cycle after the request.
- R9: A tag search returns, one cycle after the request, the tag of the lowest-indexed valid entry whose tag equals reqWdata, with rspMiss low. Invalid entries never match.
- R10: A tag search with no valid matching entry returns rspData zero with rspMiss and rspValid high for one cycle.
- R11: Opcodes 6 and 7, and any cycle with reqValid low, change no entry or register and raise neither rspValid nor fillFail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 3 | Request opcode (see R2) |
| reqAddr | input | ADDR_W | Request address; register select and entry index fields |
| reqWdata | input | WORD_W | Write data or search tag |
| rspValid | output | 1 | Read or search result valid |
| rspData | output | WORD_W | Read or search result |
| rspMiss | output | 1 | Search found no valid matching entry |
| fillFail | output | 1 | Automatic fill dropped, all entries locked |

## Verification
The bench builds the block with 8 entries and leaves the 16-register bank at its default size. With 8 entries, a few dozen requests are enough to drive the array through every state the fill priority depends on: partly invalid, all valid with unlocked slots, and fully locked. The bench sweeps every register and every entry index, and it searches for every stored tag.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam logic [2:0] OP_REG_WR = 3'd0;
  localparam logic [2:0] OP_REG_RD = 3'd1;
  localparam logic [2:0] OP_FILL   = 3'd2;
  localparam logic [2:0] OP_DIRECT = 3'd3;
  localparam logic [2:0] OP_ENT_RD = 3'd4;
  localparam logic [2:0] OP_SEARCH = 3'd5;

  typedef enum logic [1:0] {
    SEL_REG  = 2'd0,
    SEL_ENT  = 2'd1,
    SEL_SRCH = 2'd2
  } rspSel_e;

  typedef struct packed {
    logic    regWe;
    logic    entWe;
    logic    rspLoad;
    rspSel_e rspSel;
    logic    fillFail;
    logic    srchHit;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  // lowest set bit wins: scan downwards so the last assignment is the lowest
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl import tlb_pkg::*; #(
  parameter int ENTRIES   = 64,
  parameter int REG_COUNT = 16,
  parameter int ADDR_W    = 16,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int REG_SEL_W = $clog2(REG_COUNT)
) (
  input  logic                 reqValid,
  input  logic [2:0]           reqOp,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [ENTRIES-1:0]   validVec,
  input  logic [ENTRIES-1:0]   lockVec,
  input  logic [ENTRIES-1:0]   hitVec,
  output tlbStrobe_t           strb,
  output logic [IDX_W-1:0]     entIdx,
  output logic [IDX_W-1:0]     hitIdx,
  output logic [REG_SEL_W-1:0] regIdx
);

  localparam int FIELD_LSB = 3;

  logic             invFound, unlkFound, hitFound;
  logic [IDX_W-1:0] invIdx, unlkIdx;
  logic [IDX_W-1:0] addrIdx;
  logic             fillOk;
  logic             isRegWr, isRegRd, isFill, isDirect, isEntRd, isSearch;
  logic             unusedAddr;

  assign unusedAddr = ^reqAddr;

  assign addrIdx = reqAddr[FIELD_LSB +: IDX_W];
  assign regIdx  = reqAddr[FIELD_LSB +: REG_SEL_W];

  tlb_prio_enc #(.N(ENTRIES)) u_invEnc (
    .req   (~validVec),
    .found (invFound),
    .idx   (invIdx)
  );

  tlb_prio_enc #(.N(ENTRIES)) u_unlkEnc (
    .req   (~lockVec),
    .found (unlkFound),
    .idx   (unlkIdx)
  );

  tlb_prio_enc #(.N(ENTRIES)) u_hitEnc (
    .req   (hitVec & validVec),
    .found (hitFound),
    .idx   (hitIdx)
  );

  assign isRegWr  = reqValid && (reqOp == OP_REG_WR);
  assign isRegRd  = reqValid && (reqOp == OP_REG_RD);
  assign isFill   = reqValid && (reqOp == OP_FILL);
  assign isDirect = reqValid && (reqOp == OP_DIRECT);
  assign isEntRd  = reqValid && (reqOp == OP_ENT_RD);
  assign isSearch = reqValid && (reqOp == OP_SEARCH);

  // invalid slots take precedence; unlocked slots only once all are valid
  assign fillOk = invFound || unlkFound;

  always_comb begin
    if (isDirect || isEntRd) entIdx = addrIdx;
    else if (invFound)       entIdx = invIdx;
    else                     entIdx = unlkIdx;
  end

  always_comb begin
    strb          = '0;
    strb.regWe    = isRegWr;
    strb.entWe    = isDirect || (isFill && fillOk);
    strb.rspLoad  = isRegRd || isEntRd || isSearch;
    strb.fillFail = isFill && !fillOk;
    strb.srchHit  = hitFound;
    if (isEntRd)       strb.rspSel = SEL_ENT;
    else if (isSearch) strb.rspSel = SEL_SRCH;
    else               strb.rspSel = SEL_REG;
  end

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath import tlb_pkg::*; #(
  parameter int ENTRIES   = 64,
  parameter int WORD_W    = 64,
  parameter int REG_COUNT = 16,
  parameter int TAG_REG   = 6,
  parameter int FAULT_REG = 3,
  parameter int VALID_BIT = 63,
  parameter int LOCK_BIT  = 6,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int REG_SEL_W = $clog2(REG_COUNT)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  tlbStrobe_t           strb,
  input  logic [IDX_W-1:0]     entIdx,
  input  logic [IDX_W-1:0]     hitIdx,
  input  logic [REG_SEL_W-1:0] regIdx,
  input  logic [WORD_W-1:0]    reqWdata,
  output logic [ENTRIES-1:0]   validVec,
  output logic [ENTRIES-1:0]   lockVec,
  output logic [ENTRIES-1:0]   hitVec,
  output logic                 rspValid,
  output logic [WORD_W-1:0]    rspData,
  output logic                 rspMiss,
  output logic                 fillFail
);

  logic [REG_COUNT-1:0][WORD_W-1:0] regFlat;
  logic [ENTRIES-1:0][WORD_W-1:0]   tagFlat;
  logic [ENTRIES-1:0][WORD_W-1:0]   dataFlat;
  logic [WORD_W-1:0]                rspNext;

  // control register bank; the fault-status slot is a fixed zero
  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    if (g == FAULT_REG) begin : g_fault
      assign regFlat[g] = '0;
    end else begin : g_rw
      logic [WORD_W-1:0] regQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regQ <= '0;
        else if (strb.regWe && (regIdx == REG_SEL_W'(g))) regQ <= reqWdata;
      end
      assign regFlat[g] = regQ;
    end
  end

  // entry storage with per-entry status taps
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [WORD_W-1:0] tagQ;
    logic [WORD_W-1:0] dataQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagQ  <= '0;
        dataQ <= '0;
      end else if (strb.entWe && (entIdx == IDX_W'(g))) begin
        tagQ  <= regFlat[TAG_REG];
        dataQ <= reqWdata;
      end
    end
    assign tagFlat[g]  = tagQ;
    assign dataFlat[g] = dataQ;
    assign validVec[g] = dataQ[VALID_BIT];
    assign lockVec[g]  = dataQ[LOCK_BIT];
    assign hitVec[g]   = (tagQ == reqWdata);
  end

  always_comb begin
    unique case (strb.rspSel)
      SEL_ENT:  rspNext = dataFlat[entIdx];
      SEL_SRCH: rspNext = strb.srchHit ? tagFlat[hitIdx] : '0;
      default:  rspNext = regFlat[regIdx];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      rspMiss  <= 1'b0;
      fillFail <= 1'b0;
    end else begin
      rspValid <= strb.rspLoad;
      rspMiss  <= strb.rspLoad && (strb.rspSel == SEL_SRCH) && !strb.srchHit;
      fillFail <= strb.fillFail;
      if (strb.rspLoad) rspData <= rspNext;
    end
  end

endmodule

// File: rtl/tlb_fill_lookup.sv
module tlb_fill_lookup import tlb_pkg::*; #(
  parameter int ENTRIES   = 64,
  parameter int WORD_W    = 64,
  parameter int REG_COUNT = 16,
  parameter int ADDR_W    = 16,
  parameter int TAG_REG   = 6,
  parameter int FAULT_REG = 3,
  parameter int VALID_BIT = 63,
  parameter int LOCK_BIT  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic              rspMiss,
  output logic              fillFail
);

  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int REG_SEL_W = $clog2(REG_COUNT);

  tlbStrobe_t           strb;
  logic [IDX_W-1:0]     entIdx;
  logic [IDX_W-1:0]     hitIdx;
  logic [REG_SEL_W-1:0] regIdx;
  logic [ENTRIES-1:0]   validVec;
  logic [ENTRIES-1:0]   lockVec;
  logic [ENTRIES-1:0]   hitVec;

  tlb_ctrl #(
    .ENTRIES   (ENTRIES),
    .REG_COUNT (REG_COUNT),
    .ADDR_W    (ADDR_W)
  ) u_ctrl (
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqAddr  (reqAddr),
    .validVec (validVec),
    .lockVec  (lockVec),
    .hitVec   (hitVec),
    .strb     (strb),
    .entIdx   (entIdx),
    .hitIdx   (hitIdx),
    .regIdx   (regIdx)
  );

  tlb_datapath #(
    .ENTRIES   (ENTRIES),
    .WORD_W    (WORD_W),
    .REG_COUNT (REG_COUNT),
    .TAG_REG   (TAG_REG),
    .FAULT_REG (FAULT_REG),
    .VALID_BIT (VALID_BIT),
    .LOCK_BIT  (LOCK_BIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .entIdx   (entIdx),
    .hitIdx   (hitIdx),
    .regIdx   (regIdx),
    .reqWdata (reqWdata),
    .validVec (validVec),
    .lockVec  (lockVec),
    .hitVec   (hitVec),
    .rspValid (rspValid),
    .rspData  (rspData),
    .rspMiss  (rspMiss),
    .fillFail (fillFail)
  );

endmodule

// File: rtl/tlb_fill_lookup_chk.sv
module tlb_fill_lookup_chk import tlb_pkg::*; #(
  parameter int WORD_W    = 64,
  parameter int REG_COUNT = 16,
  parameter int ADDR_W    = 16,
  parameter int FAULT_REG = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqOp,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [WORD_W-1:0] reqWdata,
  input logic              rspValid,
  input logic [WORD_W-1:0] rspData,
  input logic              rspMiss,
  input logic              fillFail
);

  localparam int REG_SEL_W = $clog2(REG_COUNT);

  logic unusedChkAddr;
  assign unusedChkAddr = ^reqAddr;

  // R2: a response only follows a read or search request
  p_rsp_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && (reqOp == OP_REG_RD || reqOp == OP_ENT_RD ||
                                    reqOp == OP_SEARCH)));

  // R3: the fault-status register always reads zero
  p_fault_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_REG_RD && reqAddr[3 +: REG_SEL_W] == REG_SEL_W'(FAULT_REG))
    |=> (rspValid && rspData == '0));

  // R6: a fill failure only follows a fill request
  p_fail_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    fillFail |-> $past(reqValid && reqOp == OP_FILL));

  // R9: a search hit echoes the searched tag
  p_hit_echo_r9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_SEARCH) |=> (rspValid && (rspMiss || rspData == $past(reqWdata))));

  // R10: a miss carries zero data and a valid response
  p_miss_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (rspValid && rspData == '0));

  // R11: unused opcodes produce nothing
  p_ignored_op_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp > OP_SEARCH) |=> (!rspValid && !fillFail));

endmodule

bind tlb_fill_lookup tlb_fill_lookup_chk #(
  .WORD_W    (WORD_W),
  .REG_COUNT (REG_COUNT),
  .ADDR_W    (ADDR_W),
  .FAULT_REG (FAULT_REG)
) u_chk (.*);

// File: tb/tlb_fill_lookup_bench.sv
module tlb_fill_lookup_bench;

  localparam int ENT = 8;
  localparam int RC  = 16;
  localparam int AW  = 16;
  localparam logic [63:0] VB = 64'h8000_0000_0000_0000;
  localparam logic [63:0] LB = 64'h0000_0000_0000_0040;

  logic          clk, rstN, reqValid;
  logic [2:0]    reqOp;
  logic [AW-1:0] reqAddr;
  logic [63:0]   reqWdata;
  logic          rspValid, rspMiss, fillFail;
  logic [63:0]   rspData;

  tlb_fill_lookup #(.ENTRIES(ENT)) u_tlb_fill_lookup (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData), .rspMiss(rspMiss),
    .fillFail(fillFail)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  logic [63:0] mTag [ENT];
  logic [63:0] mData[ENT];
  logic [63:0] mReg [RC];
  logic        cV, cM, cF;
  logic [63:0] cD;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [2:0] op, input logic [AW-1:0] addr, input logic [63:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = addr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    cV = rspValid; cD = rspData; cM = rspMiss; cF = fillFail;
  endtask

  task automatic regWrite(input int r, input logic [63:0] v);
    doOp(3'd0, AW'(r * 8), v);
    mReg[r] = (r == 3) ? 64'd0 : v;
  endtask

  task automatic checkRegs(input string req);
    for (int r = 0; r < RC; r++) begin
      doOp(3'd1, AW'(r * 8), 64'd0);
      chk({req, " reg rspValid"}, 64'(cV), 64'd1);
      chk({req, " reg data"}, cD, mReg[r]);
    end
  endtask

  task automatic checkEntries(input string req);
    for (int i = 0; i < ENT; i++) begin
      doOp(3'd4, AW'(i * 8), 64'd0);
      chk({req, " R8 entry rspValid"}, 64'(cV), 64'd1);
      chk({req, " R8 entry data"}, cD, mData[i]);
    end
  endtask

  // model of the placement rule, from R4/R5/R6
  task automatic fill(input string req, input logic [63:0] v);
    int idx = -1;
    for (int i = ENT - 1; i >= 0; i--) if (!mData[i][63]) idx = i;
    if (idx < 0) for (int i = ENT - 1; i >= 0; i--) if (!mData[i][6]) idx = i;
    doOp(3'd2, '0, v);
    chk({req, " fillFail"}, 64'(cF), 64'(idx < 0));
    chk({req, " fill no rsp"}, 64'(cV), 64'd0);
    if (idx >= 0) begin
      mTag[idx]  = mReg[6];
      mData[idx] = v;
      doOp(3'd4, AW'(idx * 8), 64'd0);
      chk({req, " filled slot"}, cD, v);
    end
  endtask

  task automatic direct(input logic [AW-1:0] addr, input logic [63:0] v);
    int i = int'(addr[5:3]);
    doOp(3'd3, addr, v);
    mTag[i]  = mReg[6];
    mData[i] = v;
  endtask

  task automatic search(input string req, input logic [63:0] t);
    logic hit = 1'b0;
    for (int i = 0; i < ENT; i++) if (mData[i][63] && mTag[i] == t) hit = 1'b1;
    doOp(3'd5, '0, t);
    chk({req, " search rspValid"}, 64'(cV), 64'd1);
    chk({req, " search miss"}, 64'(cM), 64'(!hit));
    chk({req, " search data"}, cD, hit ? t : 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqOp = '0; reqAddr = '0; reqWdata = '0;
    for (int i = 0; i < ENT; i++) begin mTag[i] = '0; mData[i] = '0; end
    for (int r = 0; r < RC; r++) mReg[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rspValid", 64'(rspValid), 64'd0);
    chk("R1 rspMiss", 64'(rspMiss), 64'd0);
    chk("R1 fillFail", 64'(fillFail), 64'd0);
    checkEntries("R1");
    checkRegs("R1");

    // R2, R3: full register sweep
    for (int r = 0; r < RC; r++)
      regWrite(r, 64'hC0DE_0000_0000_0001 + 64'(r) * 64'h0101_0101);
    checkRegs("R2");
    regWrite(3, '1);
    doOp(3'd1, AW'(3 * 8), 64'd0);
    chk("R3 fault reads zero", cD, 64'd0);

    // R4: fills of invalid data keep reusing slot 0
    regWrite(6, 64'h100);
    fill("R4 invalid fill a", 64'h55);
    fill("R4 invalid fill b", 64'h77);
    checkEntries("R4");

    // R4: sweep fills, odd slots locked
    for (int i = 0; i < ENT; i++) begin
      regWrite(6, 64'h200 + 64'(i));
      fill("R4 sweep", VB | (64'(i) << 8) | ((i % 2 == 1) ? LB : 64'd0));
    end
    checkEntries("R4 full");

    // R5: all valid, fills go to lowest unlocked slot
    for (int k = 0; k < ENT / 2; k++) begin
      regWrite(6, 64'h300 + 64'(k));
      fill("R5 unlocked", VB | LB | (64'hA0 + 64'(k)) << 8);
    end
    checkEntries("R5");

    // R6: all locked, fill dropped, one-cycle flag
    fill("R6 locked", VB | 64'h1234_0000);
    @(negedge clk);
    chk("R6 flag one cycle", 64'(fillFail), 64'd0);
    checkEntries("R6");

    // R7: indexed write ignores lock and other address bits
    regWrite(6, 64'h400);
    direct(AW'(5 * 8), 64'h5);
    checkEntries("R7 invalidate");
    fill("R7 refill", VB | 64'h9900);
    direct(16'hFFC0 | AW'(2 * 8) | 16'h3, VB | 64'h4200);
    checkEntries("R7 field");

    // R9, R10: searches
    for (int i = 0; i < ENT; i++) search("R9 stored", mTag[i]);
    regWrite(6, 64'h777);
    direct(AW'(7 * 8), 64'h1);
    search("R10 invalid match", 64'h777);
    search("R10 absent", 64'hDEAD);
    search("R9 shared tag", 64'h400);

    // R11: ignored requests
    doOp(3'd6, '0, VB);
    chk("R11 op6 rsp", 64'(cV), 64'd0);
    chk("R11 op6 fail", 64'(cF), 64'd0);
    doOp(3'd7, AW'(1 * 8), VB);
    chk("R11 op7 rsp", 64'(cV), 64'd0);
    @(negedge clk);
    reqOp = 3'd3; reqAddr = AW'(0); reqWdata = 64'hFFFF;
    @(negedge clk);
    chk("R11 idle rsp", 64'(rspValid), 64'd0);
    checkEntries("R11");
    checkRegs("R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule